// File: doc/BRIEF.md
# I2C Message Sequencer

This block carries out a single I2C controller message on its own, with no software step between bytes. A descriptor is presented with a one-cycle start pulse. The descriptor holds a 7-bit or 10-bit target address, a ten-bit flag, a read flag, a flag that inverts the direction bit, a flag that skips the START and address phases, and a byte count. The sequencer then steers an existing byte-level bus engine through that engine's data and control registers. Each time the engine raises its interrupt flag, the sequencer reads the engine's status code and picks one next action from it. It then writes the address or data byte and a new control value. Bytes move between the engine and an external byte buffer, which is addressed by a running index.

The message ends with a one-cycle `done` pulse and a two-bit result: 0 = ok, 1 = no device, 2 = I/O error, 3 = timeout. A programmable cycle limit guards the whole message. When the limit expires, the sequencer enters an aborting state and waits for one more interrupt, which it answers with STOP. If a second window of the same length also passes with no interrupt, the sequencer gives up, returns to idle and raises a bus-locked flag.

The engine's control byte uses these bit positions: 2 = acknowledge enable, 4 = STOP request, 5 = START request, 6 = bus enable, 7 = interrupt enable. The engine must drop its interrupt flag no later than the clock edge at which it takes a control-register write.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `bus_locked` and `eng_we` are 0.
- R2: A 7-bit address goes out as {addr[6:0], dir}. A 10-bit address goes out first as {4'b1111, 1'b0, addr[9:8], dir} and then as addr[7:0]. dir is 1 for a read, and the reverse flag inverts it.
- R3: A normal message begins with a control write of 0xE4 (START, acknowledge, bus enable, interrupt enable). Status 0x08 or 0x10 then causes a data write of the first address byte, followed by a control write.
- R4: In a write message, status 0x18 (7-bit address), 0xD0 or 0x28 causes the next buffer byte to be sent, taking buffer indices in ascending order from 0. If no bytes remain, STOP is issued and the result is ok. Every data-register write is followed at once by a control-register write.
- R5: In a read message, status 0x40 or 0xE0 with a count of zero issues STOP. Otherwise the sequencer continues without storing a byte. Status 0x50 stores the received byte at the next buffer index. Acknowledge (bit 2) is cleared in the control value once exactly one byte is left. Status 0x58 stores the last byte and issues STOP.
- R6: With the ten-bit flag set, status 0x18 or 0x40 causes the second address byte to be sent.
- R7: Status 0x20, 0x30 or 0x48 issues STOP and ends the message with result 1 (no device).
- R8: Any status not listed for the active states issues STOP and ends the message with result 2 (I/O error).
- R9: A STOP control write has bit 4 set and bits 7 and 5 clear. Interrupt enable stays cleared in later control values.
- R10: With the skip flag set, a read first writes the control value alone and waits for data. A write sends buffer byte 0 at once, with no START.
- R11: When the cycle limit expires, the sequencer enters the aborting state. The next interrupt, whatever its status, issues STOP and ends the message with result 3.
- R12: If a second limit expires in the aborting state, the message ends with result 3, `bus_locked` = 1 and no bus write. The next start clears `bus_locked`.
- R13: An interrupt while idle issues a STOP control write and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Start pulse, accepted while not busy |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | Ten-bit addressing |
| msg_rd | input | 1 | Read message |
| msg_rev | input | 1 | Invert direction bit |
| msg_nostart | input | 1 | Skip START and address phases |
| msg_len | input | LEN_W | Byte count |
| tmo_limit | input | TMO_W | Timeout window in cycles |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| result | output | 2 | Outcome code, held after done |
| bus_locked | output | 1 | Abort window expired |
| eng_iflag | input | 1 | Engine interrupt flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine data register |
| eng_we | output | 1 | Engine register write strobe |
| eng_reg | output | 1 | 0 = data register, 1 = control register |
| eng_wdata | output | 8 | Engine write value |
| buf_idx | output | LEN_W | Byte buffer index |
| buf_rdata | input | 8 | Buffer byte at buf_idx |
| buf_we | output | 1 | Buffer store strobe |
| buf_wdata | output | 8 | Buffer store value |

## Verification
A scripted engine model answers each non-STOP control write with a queued status code. This lets one bench drive many paths:
- 7-bit writes and reads, which separate the write and read status trees.
- 10-bit addresses, with and without the reverse flag, which expose errors in address-byte packing and in second-byte handling.
- A three-byte read, which shows whether acknowledge drops on exactly the right byte.
- The skip-START variants, which show the skipped phases.
- Negative and unknown status codes, which tell the no-device and I/O-error results apart.
- A delayed interrupt and a missing interrupt, which tell the single-timeout outcome from the bus-locked outcome.
- A stray interrupt after lock-up, which confirms that idle STOP handling produces no completion.

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer #(
  parameter int LEN_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic             msg_rev,
  input  logic             msg_nostart,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             bus_locked,
  input  logic             eng_iflag,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_rdata,
  output logic             eng_we,
  output logic             eng_reg,
  output logic [7:0]       eng_wdata,
  output logic [LEN_W-1:0] buf_idx,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata
);
  localparam int ACK_B = 2, STOP_B = 4, START_B = 5, EN_B = 6, INTEN_B = 7;
  localparam logic [7:0] ACK_M   = 8'(1 << ACK_B);
  localparam logic [7:0] STOP_M  = 8'(1 << STOP_B);
  localparam logic [7:0] START_M = 8'(1 << START_B);
  localparam logic [7:0] EN_M    = 8'(1 << EN_B);
  localparam logic [7:0] INTEN_M = 8'(1 << INTEN_B);
  localparam logic [7:0] CTL_INIT = ACK_M | EN_M | INTEN_M;

  localparam logic [7:0] SC_START = 8'h08, SC_RSTART = 8'h10;
  localparam logic [7:0] SC_WA_ACK = 8'h18, SC_WA_NACK = 8'h20;
  localparam logic [7:0] SC_WD_ACK = 8'h28, SC_WD_NACK = 8'h30;
  localparam logic [7:0] SC_RA_ACK = 8'h40, SC_RA_NACK = 8'h48;
  localparam logic [7:0] SC_RD_ACK = 8'h50, SC_RD_NACK = 8'h58;
  localparam logic [7:0] SC_WA2_ACK = 8'hD0, SC_RA2_ACK = 8'hE0;

  localparam logic [1:0] RES_OK = 2'd0, RES_NODEV = 2'd1, RES_IOERR = 2'd2, RES_TMO = 2'd3;

  typedef enum logic [2:0] {
    S_INVALID, S_IDLE, S_WSTART, S_WADDR1, S_WADDR2, S_WACK, S_WDATA, S_ABORT
  } state_t;

  typedef enum logic [3:0] {
    A_NONE, A_CONT, A_START, A_ADDR1, A_ADDR2, A_DATA, A_RCV, A_RCV_STOP, A_STOP
  } act_t;

  state_t           state, d_state;
  act_t             act, d_act;
  logic             phase;
  logic [7:0]       ctl;
  logic [7:0]       addr1, addr2;
  logic [LEN_W-1:0] left, d_left, pos;
  logic             ten_r, active;
  logic [TMO_W-1:0] tmr;
  logic             d_clr, d_store;
  logic [1:0]       d_res;

  logic       dir;
  logic [7:0] a1_new;
  logic       take_start, take_irq, tmo_hit, is_stop, has_data;

  assign dir        = msg_rd ^ msg_rev;
  assign a1_new     = msg_ten ? {4'b1111, 1'b0, msg_addr[9:8], dir} : {msg_addr[6:0], dir};
  assign take_start = msg_start && !active && (act == A_NONE);
  assign take_irq   = eng_iflag && (act == A_NONE) && !take_start;
  assign tmo_hit    = active && (act == A_NONE) && !eng_iflag && (tmr >= tmo_limit);
  assign is_stop    = (act == A_STOP) || (act == A_RCV_STOP);
  assign has_data   = (act == A_ADDR1) || (act == A_ADDR2) || (act == A_DATA);

  assign busy      = active;
  assign eng_we    = (act != A_NONE);
  assign eng_reg   = !(has_data && !phase);
  assign buf_idx   = pos;
  assign buf_wdata = eng_rdata;
  assign buf_we    = take_irq && d_store;

  always_comb begin
    if (!eng_reg) begin
      case (act)
        A_ADDR1: eng_wdata = addr1;
        A_ADDR2: eng_wdata = addr2;
        default: eng_wdata = buf_rdata;
      endcase
    end else if (is_stop) begin
      eng_wdata = (ctl & ~INTEN_M) | STOP_M;
    end else if (act == A_START) begin
      eng_wdata = ctl | START_M;
    end else begin
      eng_wdata = ctl;
    end
  end

  always_comb begin
    d_state = S_IDLE;
    d_act   = A_STOP;
    d_left  = left;
    d_clr   = 1'b0;
    d_store = 1'b0;
    d_res   = result;
    if (state != S_IDLE && state != S_ABORT && state != S_INVALID) begin
      case (eng_status)
        SC_START, SC_RSTART: begin
          d_act   = A_ADDR1;
          d_state = S_WADDR1;
        end
        SC_WA_ACK, SC_WA2_ACK, SC_WD_ACK: begin
          if (ten_r && eng_status == SC_WA_ACK) begin
            d_act   = A_ADDR2;
            d_state = S_WADDR2;
          end else if (left != '0) begin
            d_act   = A_DATA;
            d_state = S_WACK;
            d_left  = left - LEN_W'(1);
          end
        end
        SC_RA_ACK, SC_RA2_ACK: begin
          if (ten_r && eng_status == SC_RA_ACK) begin
            d_act   = A_ADDR2;
            d_state = S_WADDR2;
          end else if (left != '0) begin
            d_act   = A_CONT;
            d_state = S_WDATA;
            d_clr   = (left == LEN_W'(1));
          end
        end
        SC_RD_ACK: begin
          d_act   = A_RCV;
          d_state = S_WDATA;
          d_store = 1'b1;
          d_left  = left - LEN_W'(1);
          d_clr   = (left == LEN_W'(2));
        end
        SC_RD_NACK: begin
          d_act   = A_RCV_STOP;
          d_store = 1'b1;
        end
        SC_WA_NACK, SC_WD_NACK, SC_RA_NACK: d_res = RES_NODEV;
        default: d_res = RES_IOERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      act        <= A_NONE;
      phase      <= 1'b0;
      ctl        <= CTL_INIT;
      addr1      <= '0;
      addr2      <= '0;
      left       <= '0;
      pos        <= '0;
      ten_r      <= 1'b0;
      active     <= 1'b0;
      done       <= 1'b0;
      result     <= RES_OK;
      bus_locked <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take_start) begin
        active     <= 1'b1;
        result     <= RES_OK;
        bus_locked <= 1'b0;
        pos        <= '0;
        phase      <= 1'b0;
        ctl        <= CTL_INIT;
        ten_r      <= msg_ten;
        addr1      <= a1_new;
        addr2      <= msg_ten ? msg_addr[7:0] : 8'h00;
        if (!msg_nostart) begin
          act   <= A_START;
          state <= S_WSTART;
          left  <= msg_len;
        end else if (msg_rd) begin
          act   <= A_CONT;
          state <= S_WDATA;
          left  <= msg_len;
        end else if (msg_len != '0) begin
          act   <= A_DATA;
          state <= S_WACK;
          left  <= msg_len - LEN_W'(1);
        end else begin
          act   <= A_STOP;
          state <= S_IDLE;
          left  <= '0;
        end
      end else if (take_irq) begin
        state  <= d_state;
        act    <= d_act;
        left   <= d_left;
        result <= d_res;
        if (d_clr) ctl[ACK_B] <= 1'b0;
        if (d_store) pos <= pos + LEN_W'(1);
      end else if (act != A_NONE) begin
        if (has_data && !phase) begin
          phase <= 1'b1;
          if (act == A_DATA) pos <= pos + LEN_W'(1);
        end else begin
          phase <= 1'b0;
          act   <= A_NONE;
          if (is_stop) begin
            ctl[INTEN_B] <= 1'b0;
            if (active) begin
              done   <= 1'b1;
              active <= 1'b0;
            end
          end
        end
      end else if (tmo_hit) begin
        if (state == S_ABORT) begin
          state      <= S_IDLE;
          active     <= 1'b0;
          done       <= 1'b1;
          bus_locked <= 1'b1;
        end else begin
          state  <= S_ABORT;
          result <= RES_TMO;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tmr <= '0;
    else if (take_start || tmo_hit)  tmr <= '0;
    else if (active && tmr < tmo_limit) tmr <= tmr + TMO_W'(1);
  end

  assert_ctl_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && eng_reg) |-> eng_wdata[EN_B]);

  assert_stop_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && eng_reg && eng_wdata[STOP_B]) |-> (!eng_wdata[INTEN_B] && !eng_wdata[START_B]));

  assert_data_then_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && !eng_reg) |=> (eng_we && eng_reg));

  assert_store_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !eng_we);

  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_lock_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_locked |-> (result == RES_TMO));

  assert_lock_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_locked) |-> done);
endmodule

// File: tb/test_i2c_msg_sequencer.sv
module test_i2c_msg_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n;
  logic       msg_start, msg_ten, msg_rd, msg_rev, msg_nostart;
  logic [9:0] msg_addr;
  logic [7:0] msg_len;
  logic [15:0] tmo_limit;
  logic       busy, done, bus_locked;
  logic [1:0] result;
  logic       eng_iflag;
  logic [7:0] eng_status, eng_rdata;
  logic       eng_we, eng_reg;
  logic [7:0] eng_wdata;
  logic [7:0] buf_idx, buf_rdata, buf_wdata;
  logic       buf_we;

  logic [7:0] mem [0:15];
  assign buf_rdata = mem[buf_idx[3:0]];
  always @(posedge clk) if (buf_we) mem[buf_idx[3:0]] <= buf_wdata;

  i2c_msg_sequencer #(.LEN_W(8), .TMO_W(16)) i_i2c_msg_sequencer (
    .clk(clk), .rst_n(rst_n),
    .msg_start(msg_start), .msg_addr(msg_addr), .msg_ten(msg_ten), .msg_rd(msg_rd),
    .msg_rev(msg_rev), .msg_nostart(msg_nostart), .msg_len(msg_len), .tmo_limit(tmo_limit),
    .busy(busy), .done(done), .result(result), .bus_locked(bus_locked),
    .eng_iflag(eng_iflag), .eng_status(eng_status), .eng_rdata(eng_rdata),
    .eng_we(eng_we), .eng_reg(eng_reg), .eng_wdata(eng_wdata),
    .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata)
  );

  int errs = 0;
  int n_chk = 0;
  int done_cnt = 0;
  string cur_req = "R1";
  logic [8:0]  exp_q [$];
  logic [23:0] resp_q [$];
  int pend = 0;
  logic pending = 1'b0;
  logic [7:0] p_stat = 8'h00, p_data = 8'h00;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic push_w(input logic r, input logic [7:0] v);
    exp_q.push_back({r, v});
  endtask

  task automatic push_r(input logic [7:0] st, input logic [7:0] d, input logic [7:0] dly);
    resp_q.push_back({dly, st, d});
  endtask

  // monitor: scoreboard of engine writes and done pulses
  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (eng_we) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          errs++;
          $display("FAIL %s write: actual %0h expected none", cur_req, {eng_reg, eng_wdata});
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if (e !== {eng_reg, eng_wdata}) begin
            errs++;
            $display("FAIL %s write: actual %0h expected %0h", cur_req, {eng_reg, eng_wdata}, e);
          end
        end
      end
    end
  end

  // engine model: clears flag on control write, answers with queued status
  initial begin
    eng_iflag = 1'b0; eng_status = 8'hF8; eng_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (eng_we && eng_reg) begin
        eng_iflag = 1'b0;
        if (!eng_wdata[4] && resp_q.size() > 0) begin
          logic [23:0] r;
          r = resp_q.pop_front();
          pend = int'(r[23:16]); p_stat = r[15:8]; p_data = r[7:0]; pending = 1'b1;
        end
      end else if (pending) begin
        if (pend == 0) begin
          eng_status = p_stat; eng_rdata = p_data; eng_iflag = 1'b1; pending = 1'b0;
        end else pend--;
      end
    end
  end

  task automatic run(input string req, input logic [9:0] a, input logic ten, input logic rd,
                     input logic rev, input logic ns, input logic [7:0] len,
                     input int eres, input int elock);
    int base;
    int w;
    cur_req = req;
    @(negedge clk);
    base = done_cnt;
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_rev = rev; msg_nostart = ns; msg_len = len;
    msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    w = 0;
    while (done_cnt == base && w < 3000) begin
      @(negedge clk);
      w++;
    end
    chk(req, "done seen", int'(done_cnt != base), 1);
    chk(req, "result", int'(result), eres);
    chk(req, "bus_locked", int'(bus_locked), elock);
    chk(req, "writes left", exp_q.size(), 0);
    chk(req, "responses left", resp_q.size(), 0);
    exp_q.delete();
    resp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_start = 1'b0; msg_addr = '0; msg_ten = 0; msg_rd = 0; msg_rev = 0;
    msg_nostart = 0; msg_len = '0; tmo_limit = 16'd40;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "bus_locked", int'(bus_locked), 0);
    chk("R1", "eng_we", int'(eng_we), 0);

    // R3 R4 R9: 7-bit write of two bytes
    mem[0] = 8'hA1; mem[1] = 8'hB2;
    push_w(1, 8'hE4); push_w(0, 8'hA0); push_w(1, 8'hC4);
    push_w(0, 8'hA1); push_w(1, 8'hC4); push_w(0, 8'hB2); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h18, 0, 2); push_r(8'h28, 0, 0); push_r(8'h28, 0, 3);
    run("R4", 10'h050, 0, 0, 0, 0, 8'd2, 0, 0);

    // R5: 7-bit read of three bytes, ack cleared before the last
    push_w(1, 8'hE4); push_w(0, 8'h43); push_w(1, 8'hC4); push_w(1, 8'hC4);
    push_w(1, 8'hC4); push_w(1, 8'hC0); push_w(1, 8'h50);
    push_r(8'h08, 0, 1); push_r(8'h40, 0, 1); push_r(8'h50, 8'h3C, 1);
    push_r(8'h50, 8'h4D, 1); push_r(8'h58, 8'h5E, 1);
    run("R5", 10'h021, 0, 1, 0, 0, 8'd3, 0, 0);
    chk("R5", "byte0", int'(mem[0]), 'h3C);
    chk("R5", "byte1", int'(mem[1]), 'h4D);
    chk("R5", "byte2", int'(mem[2]), 'h5E);

    // R2 R6 R3: 10-bit write, repeated-start status
    mem[0] = 8'h5C;
    push_w(1, 8'hE4); push_w(0, 8'hF4); push_w(1, 8'hC4); push_w(0, 8'hA5); push_w(1, 8'hC4);
    push_w(0, 8'h5C); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h10, 0, 1); push_r(8'h18, 0, 1); push_r(8'hD0, 0, 1); push_r(8'h28, 0, 1);
    run("R6", 10'h2A5, 1, 0, 0, 0, 8'd1, 0, 0);

    // R2 R6: 10-bit read through the reverse flag, one byte
    push_w(1, 8'hE4); push_w(0, 8'hF3); push_w(1, 8'hC4); push_w(0, 8'hFF); push_w(1, 8'hC4);
    push_w(1, 8'hC0); push_w(1, 8'h50);
    push_r(8'h08, 0, 1); push_r(8'h40, 0, 1); push_r(8'hE0, 0, 1); push_r(8'h58, 8'h7E, 1);
    run("R2", 10'h1FF, 1, 0, 1, 0, 8'd1, 0, 0);
    chk("R2", "read byte", int'(mem[0]), 'h7E);

    // R7: no device on write address and on read address
    push_w(1, 8'hE4); push_w(0, 8'h24); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h20, 0, 1);
    run("R7", 10'h012, 0, 0, 0, 0, 8'd1, 1, 0);
    push_w(1, 8'hE4); push_w(0, 8'h25); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h48, 0, 1);
    run("R7", 10'h012, 0, 1, 0, 0, 8'd2, 1, 0);

    // R8: unexpected status
    push_w(1, 8'hE4); push_w(0, 8'h24); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h38, 0, 1);
    run("R8", 10'h012, 0, 0, 0, 0, 8'd1, 2, 0);

    // R5: read with zero count
    push_w(1, 8'hE4); push_w(0, 8'h67); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h40, 0, 1);
    run("R5", 10'h033, 0, 1, 0, 0, 8'd0, 0, 0);

    // R10: skip-START write and read
    mem[0] = 8'h11; mem[1] = 8'h22;
    push_w(0, 8'h11); push_w(1, 8'hC4); push_w(0, 8'h22); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h28, 0, 1); push_r(8'h28, 0, 1);
    run("R10", 10'h050, 0, 0, 0, 1, 8'd2, 0, 0);
    push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h58, 8'h99, 1);
    run("R10", 10'h050, 0, 1, 0, 1, 8'd1, 0, 0);
    chk("R10", "read byte", int'(mem[0]), 'h99);

    // R11: interrupt arrives after the first window
    push_w(1, 8'hE4); push_w(0, 8'hA0); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h18, 0, 60);
    run("R11", 10'h050, 0, 0, 0, 0, 8'd1, 3, 0);

    // R12: no interrupt at all
    push_w(1, 8'hE4);
    run("R12", 10'h050, 0, 0, 0, 0, 8'd1, 3, 1);

    // R13: stray interrupt while idle
    begin
      int base;
      cur_req = "R13";
      base = done_cnt;
      push_w(1, 8'h54);
      @(negedge clk);
      p_stat = 8'hF8; p_data = 8'h00; pend = 0; pending = 1'b1;
      repeat (10) @(negedge clk);
      chk("R13", "stop write seen", exp_q.size(), 0);
      chk("R13", "no done", done_cnt - base, 0);
      chk("R13", "busy", int'(busy), 0);
      exp_q.delete();
    end

    // R12: next start clears the lock flag
    push_w(1, 8'hE4); push_w(0, 8'h67); push_w(1, 8'hC4); push_w(1, 8'h54);
    push_r(8'h08, 0, 1); push_r(8'h40, 0, 1);
    run("R12", 10'h033, 0, 1, 0, 0, 8'd0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, n_chk);
    $finish;
  end
endmodule